// File: doc/BRIEF.md
# DMA Parameter-Set Transfer Sequencer

The sequencer holds a single DMA parameter set and turns each synchronization event into a stream of byte-wide source/destination address pairs. A set describes a two-dimensional transfer: a number of arrays, each a fixed number of bytes long. Consecutive arrays are placed apart by a signed stride of their own for the source and for the destination. Each event authorizes either one array or the whole frame of arrays, depending on the set's synchronization mode. Each side can either step through memory or stay inside a small window that behaves like a FIFO port.

The downstream mover consumes one address pair per cycle in which `xfer_valid` and `xfer_ack` are both high. When a transfer counts as complete, one bit of a sticky 32-bit pending vector is set. A completion code in the options word selects the bit. The transfer can count as complete when its last beat is accepted, or at once when the request starts. After the transfer the stored set either advances, ready for the next event, or stays as it was.

Top module: `dma_param_sequencer`

## Requirements
- R1: `pend` resets to zero, and each bit stays set until reset. A completion code from 0 to 31 sets bit `pend[code]`. A completion code from 32 to 63 sets no bit.
- R2: With the completion-mode bit at 0, the pending bit is not yet set while the first beat is shown. It is set on the clock edge that accepts the last beat.
- R3: With the completion-mode bit at 1, the pending bit is set on the clock edge that starts the transfer, so it is already visible with the first beat.
- R4: With the sync-dimension bit at 0, an event produces exactly ACNT beats, which together form one array. `xfer_valid` then drops.
- R5: With the sync-dimension bit at 1, an event produces BCNT arrays of ACNT beats each, one after another. `xfer_valid` then drops.
- R6: With its mode bit at 0, a side's address for beat i of an array equals the array base plus i.
- R7: With its mode bit at 1, a side's address for beat i of an array equals the array base plus (i mod F). F is the FIFO width in bytes. FIFO-width codes 0 to 5 give F = 1, 2, 4, 8, 16 and 32. Codes 6 and 7 are treated as F = 1, so the address stays constant.
- R8: From one array to the next, the source base moves by its own sign-extended 16-bit index, and the destination base moves by its own.
- R9: With the static bit at 0, the stored set advances after each transfer. Both bases move past the arrays just sent, and BCNT drops by the number of arrays sent. With the static bit at 1, the stored set is left as it was, so the next event repeats the same addresses.
- R10: An event that starts while ACNT or BCNT is zero raises `evt_err` for exactly one cycle and produces no beats.
- R11: One event that arrives while a transfer is active is held and starts as soon as the transfer ends. Further events during the same transfer are dropped.
- R12: While `xfer_ack` is low, `xfer_valid` and both addresses hold their values.
- R13: After reset, `xfer_valid`, `evt_err` and `pend` are all zero.
- R14: A write with `cfg_we` high stores `cfg_wdata` into the register that `cfg_addr` selects: 0 options, 1 source base, 2 destination base, 3 ACNT, 4 BCNT, 5 source index, 6 destination index. The counts and indices use the low 16 bits. The options fields are: bits 17:12 completion code, bit 11 completion mode, bits 10:8 FIFO width, bit 3 static, bit 2 sync dimension, bit 1 destination mode, bit 0 source mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| evt | input | 1 | Synchronization event |
| xfer_ack | input | 1 | Current beat accepted by the data mover |
| xfer_valid | output | 1 | An address pair is presented |
| xfer_src | output | 32 | Source byte address |
| xfer_dst | output | 32 | Destination byte address |
| evt_err | output | 1 | One-cycle pulse for an event with a zero count |
| pend | output | 32 | Sticky completion-pending vector |

## Verification
Faults in the beat or array counters show up at once as a wrong address on the beat they disturb. They also show up as a beat count that is one too long or too short, seen in the cycle `xfer_valid` should have dropped. Faults in the stored set surface only on the next event. That is why every programmed set is fired twice: the second event shows whether the update, the static hold or the zero-count error behaved. Errors in the completion point show up as a pending bit one transfer-length early or late, checked against the first beat and against the cycle after the last.

// File: rtl/dma_param_sequencer.sv
module dma_param_sequencer #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          evt,
  input  logic          xfer_ack,
  output logic          xfer_valid,
  output logic [AW-1:0] xfer_src,
  output logic [AW-1:0] xfer_dst,
  output logic          evt_err,
  output logic [31:0]   pend
);

  logic [5:0]    code;
  logic          early, stat, absync, dmode, smode;
  logic [2:0]    fwid;
  logic [AW-1:0] src_r, dst_r, wsrc, wdst;
  logic [CW-1:0] acnt_r, bcnt_r, wcnt, ai, al;
  logic [IW-1:0] sidx_r, didx_r;
  logic          busy, evt_q;

  logic [AW-1:0] fmask, beat, sstep, dstep;
  logic          go, bad, start, beat_done, last_beat, last_arr, finish, set_bit;

  assign fmask     = (fwid <= 3'd5) ? ((AW'(1) << fwid) - AW'(1)) : '0;
  assign beat      = AW'(ai);
  assign sstep     = {{(AW-IW){sidx_r[IW-1]}}, sidx_r};
  assign dstep     = {{(AW-IW){didx_r[IW-1]}}, didx_r};
  assign xfer_valid = busy;
  assign xfer_src  = wsrc + (smode ? (beat & fmask) : beat);
  assign xfer_dst  = wdst + (dmode ? (beat & fmask) : beat);

  assign go        = !busy && (evt || evt_q);
  assign bad       = (acnt_r == '0) || (bcnt_r == '0);
  assign start     = go && !bad;
  assign beat_done = busy && xfer_ack;
  assign last_beat = (ai == acnt_r - CW'(1));
  assign last_arr  = (al == CW'(1));
  assign finish    = beat_done && last_beat && last_arr;
  assign set_bit   = !code[5] && ((start && early) || (finish && !early));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0; early <= 1'b0; fwid <= '0; stat <= 1'b0;
      absync <= 1'b0; dmode <= 1'b0; smode <= 1'b0;
      src_r <= '0; dst_r <= '0; acnt_r <= '0; bcnt_r <= '0;
      sidx_r <= '0; didx_r <= '0;
      wsrc <= '0; wdst <= '0; wcnt <= '0; ai <= '0; al <= '0;
      busy <= 1'b0; evt_q <= 1'b0; evt_err <= 1'b0; pend <= '0;
    end else begin
      evt_err <= go && bad;

      if (go)
        evt_q <= evt_q && evt;
      else if (busy && evt)
        evt_q <= 1'b1;

      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin
            code   <= cfg_wdata[17:12];
            early  <= cfg_wdata[11];
            fwid   <= cfg_wdata[10:8];
            stat   <= cfg_wdata[3];
            absync <= cfg_wdata[2];
            dmode  <= cfg_wdata[1];
            smode  <= cfg_wdata[0];
          end
          3'd1: src_r  <= cfg_wdata[AW-1:0];
          3'd2: dst_r  <= cfg_wdata[AW-1:0];
          3'd3: acnt_r <= cfg_wdata[CW-1:0];
          3'd4: bcnt_r <= cfg_wdata[CW-1:0];
          3'd5: sidx_r <= cfg_wdata[IW-1:0];
          3'd6: didx_r <= cfg_wdata[IW-1:0];
          default: ;
        endcase
      end

      if (start) begin
        busy <= 1'b1;
        ai   <= '0;
        al   <= absync ? bcnt_r : CW'(1);
        wsrc <= src_r;
        wdst <= dst_r;
        wcnt <= bcnt_r;
      end

      if (beat_done) begin
        if (last_beat) begin
          ai   <= '0;
          al   <= al - CW'(1);
          wcnt <= wcnt - CW'(1);
          wsrc <= wsrc + sstep;
          wdst <= wdst + dstep;
          if (last_arr) begin
            busy <= 1'b0;
            if (!stat) begin
              src_r  <= wsrc + sstep;
              dst_r  <= wdst + dstep;
              bcnt_r <= wcnt - CW'(1);
            end
          end
        end else begin
          ai <= ai + CW'(1);
        end
      end

      if (set_bit)
        pend[code[4:0]] <= 1'b1;
    end
  end

endmodule

module dma_param_sequencer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_valid,
  input logic          xfer_ack,
  input logic [AW-1:0] xfer_src,
  input logic [AW-1:0] xfer_dst,
  input logic          evt_err,
  input logic [31:0]   pend
);

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & $past(pend)) == $past(pend)); // R1

  AST_PEND_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend ^ $past(pend)) <= 1); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ack) |=> (xfer_valid && $stable(xfer_src) && $stable(xfer_dst))); // R12

  AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> !xfer_valid); // R10

  AST_END_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_valid) |-> $past(xfer_ack)); // R4

endmodule

bind dma_param_sequencer dma_param_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_ack(xfer_ack),
  .xfer_src(xfer_src), .xfer_dst(xfer_dst), .evt_err(evt_err), .pend(pend)
);

// File: tb/dma_param_sequencer_test.sv
`timescale 1ns/1ps
module dma_param_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        evt = 1'b0;
  logic        xfer_ack = 1'b1;
  logic        xfer_valid, evt_err;
  logic [31:0] xfer_src, xfer_dst, pend;

  always #2.5 clk = ~clk;

  dma_param_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .evt(evt), .xfer_ack(xfer_ack),
    .xfer_valid(xfer_valid), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .evt_err(evt_err), .pend(pend)
  );

  typedef struct packed {
    logic [17:0] opt;
    logic [31:0] src, dst;
    logic [15:0] acnt, bcnt, sidx, didx;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{18'h03000, 32'h1000, 32'h2000, 16'd4, 16'd3, 16'h0010, 16'h0020},
    '{18'h05004, 32'h3000, 32'h4000, 16'd3, 16'd2, 16'hFFF8, 16'h0004},
    '{18'h07101, 32'h5000, 32'h6000, 16'd5, 16'd2, 16'h0002, 16'h0005},
    '{18'h1F206, 32'h7000, 32'h8000, 16'd6, 16'd2, 16'h0006, 16'h0040},
    '{18'h28008, 32'h9000, 32'hA000, 16'd2, 16'd2, 16'h0001, 16'h0001},
    '{18'h09804, 32'hB000, 32'hC000, 16'd2, 16'd3, 16'h0010, 16'h0010},
    '{18'h0C603, 32'hD000, 32'hE000, 16'd3, 16'd1, 16'h0000, 16'h0000}
  };

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_pend = '0;
  logic [31:0] m_src, m_dst, m_sidx, m_didx;
  logic [15:0] m_acnt, m_bcnt;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load(input vec_t v);
    wr(3'd0, {14'd0, v.opt});
    wr(3'd1, v.src);
    wr(3'd2, v.dst);
    wr(3'd3, {16'd0, v.acnt});
    wr(3'd4, {16'd0, v.bcnt});
    wr(3'd5, {16'd0, v.sidx});
    wr(3'd6, {16'd0, v.didx});
    m_src = v.src; m_dst = v.dst; m_acnt = v.acnt; m_bcnt = v.bcnt;
    m_sidx = {{16{v.sidx[15]}}, v.sidx};
    m_didx = {{16{v.didx[15]}}, v.didx};
  endtask

  task automatic fire();
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic run_event(input logic [17:0] opt, input int ev);
    logic [5:0]  tcc;
    logic [31:0] mask, s, d, es, ed, first_exp;
    int narr;
    string tag;
    tcc = opt[17:12];
    mask = (opt[10:8] <= 3'd5) ? ((32'd1 << opt[10:8]) - 32'd1) : 32'd0;
    fire();
    if (m_acnt == 0 || m_bcnt == 0) begin
      check(evt_err === 1'b1 && xfer_valid === 1'b0, "R10", "zero-count error pulse",
            {30'd0, evt_err, xfer_valid}, 32'h2);
      @(negedge clk);
      check(evt_err === 1'b0 && xfer_valid === 1'b0, "R10", "error is one cycle, no beats",
            {30'd0, evt_err, xfer_valid}, 32'h0);
      return;
    end
    narr = opt[2] ? int'(m_bcnt) : 1;
    s = m_src; d = m_dst;
    for (int a = 0; a < narr; a++) begin
      for (int i = 0; i < int'(m_acnt); i++) begin
        if (a == 0 && i == 0) begin
          first_exp = exp_pend;
          if (opt[11] && !tcc[5]) first_exp[tcc[4:0]] = 1'b1;
          check(pend === first_exp, opt[11] ? "R3" : "R2", "pending at first beat",
                pend, first_exp);
        end
        es = s + (opt[0] ? (32'(i) & mask) : 32'(i));
        ed = d + (opt[1] ? (32'(i) & mask) : 32'(i));
        if (ev == 1) tag = "R9";
        else if (opt[1:0] != 2'b00) tag = "R7";
        else if (a > 0) tag = "R8";
        else tag = "R6";
        check(xfer_valid === 1'b1 && xfer_src === es, tag, "source address", xfer_src, es);
        check(xfer_valid === 1'b1 && xfer_dst === ed, tag, "destination address", xfer_dst, ed);
        @(negedge clk);
      end
      s = s + m_sidx;
      d = d + m_didx;
    end
    if (!tcc[5]) exp_pend[tcc[4:0]] = 1'b1;
    check(pend === exp_pend, "R1", "pending after transfer", pend, exp_pend);
    check(xfer_valid === 1'b0, opt[2] ? "R5" : "R4", "valid drops after last beat",
          {31'd0, xfer_valid}, 32'd0);
    if (!opt[3]) begin
      m_src = s; m_dst = d; m_bcnt = m_bcnt - 16'(narr);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(xfer_valid === 1'b0 && evt_err === 1'b0 && pend === 32'd0, "R13", "reset state",
          pend, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      load(VEC[k]);
      run_event(VEC[k].opt, 0);
      @(negedge clk);
      run_event(VEC[k].opt, 1);
      @(negedge clk);
    end

    // R12: beat held while acknowledge is low
    load('{18'h0D000, 32'h100, 32'h200, 16'd3, 16'd1, 16'h0, 16'h0});
    xfer_ack = 1'b0;
    fire();
    for (int c = 0; c < 3; c++) begin
      check(xfer_valid === 1'b1 && xfer_src === 32'h100 && xfer_dst === 32'h200, "R12",
            "stalled beat", xfer_src, 32'h100);
      @(negedge clk);
    end
    xfer_ack = 1'b1;
    @(negedge clk);
    check(xfer_src === 32'h101 && xfer_dst === 32'h201, "R12", "beat after stall",
          xfer_src, 32'h101);
    @(negedge clk);
    @(negedge clk);
    exp_pend[13] = 1'b1;
    check(xfer_valid === 1'b0 && pend === exp_pend, "R2", "end after stall", pend, exp_pend);

    // R11: one event held during a transfer, the second dropped
    load('{18'h02000, 32'h300, 32'h400, 16'd2, 16'd3, 16'h10, 16'h20});
    fire();
    check(xfer_src === 32'h300, "R11", "first array beat 0", xfer_src, 32'h300);
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
    check(xfer_src === 32'h301, "R11", "first array beat 1", xfer_src, 32'h301);
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
    check(xfer_valid === 1'b0, "R11", "gap between transfers", {31'd0, xfer_valid}, 32'd0);
    @(negedge clk);
    check(xfer_valid === 1'b1 && xfer_src === 32'h310 && xfer_dst === 32'h420, "R11",
          "held event starts", xfer_src, 32'h310);
    @(negedge clk);
    check(xfer_src === 32'h311, "R11", "held event beat 1", xfer_src, 32'h311);
    @(negedge clk);
    @(negedge clk);
    exp_pend[2] = 1'b1;
    check(xfer_valid === 1'b0 && pend === exp_pend, "R11", "extra event dropped",
          pend, exp_pend);

    // R10: zero ACNT
    wr(3'd3, 32'd0);
    fire();
    check(evt_err === 1'b1 && xfer_valid === 1'b0, "R10", "zero ACNT error",
          {31'd0, evt_err}, 32'd1);
    @(negedge clk);

    // R14: options field positions via a rewrite of the code field
    wr(3'd3, 32'd1);
    wr(3'd0, {14'd0, 18'h14800});
    fire();
    exp_pend[20] = 1'b1;
    check(pend === exp_pend, "R14", "code field at bits 17:12, early bit 11", pend, exp_pend);
    @(negedge clk);

    finish_run();
  end

endmodule